// File: doc/BRIEF.md
# GPIO Interrupt Detect and Status Unit

This unit watches 32 general-purpose input pins and turns their activity into interrupt requests. The pins are grouped into a low half (pins 0 to 15) and a high half (pins 16 to 31). Each half owns a set of 16-bit configuration and status words on a simple halfword-wide register bus. For every pin, software chooses between level and edge detection, the polarity that counts as active in level mode, which edges count in edge mode, and whether an edge event is held until software clears it or only passes through for one cycle.

Every pin input first crosses a two-flop synchroniser. The detected events set per-pin pending bits, which are cleared by writing ones. Each pending bit is ANDed with its own enable bit. The qualified bits feed one combined interrupt line and a vector that names the lowest-numbered qualified pin. All low-half pins rank ahead of all high-half pins. A cascade handler reads the vector, services the pin and clears its pending bit.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every enable, type, hold, falling-select and rising-select bit is 0, every active-level bit is 1 (high active), every pending bit is 0, and `irq` and `irq_vec_valid` are 0.
- R2: The halfword address is `bus_addr[5:1]`. Bit 1 picks the half (0 low, 1 high) and bits 5:2 pick the word: 2 pending, 3 enable, 4 type, 5 active level, 6 hold, 8 falling select, 9 rising select. `bus_rdata` returns the addressed word one clock after the address is presented. Other addresses read 0, and writes to them change nothing.
- R3: A pin change reaches its pending bit on the third rising clock edge after it is driven, and reaches `irq` on the fourth.
- R4: With a type bit of 0 (level mode), the pending bit is 1 in every cycle where the synchronised pin equals its active level (1 = high active, 0 = low active). A clearing write has no lasting effect while the condition persists.
- R5: With a type bit of 1 (edge mode), a 0-to-1 transition is an event when the rising select is 1, and a 1-to-0 transition is an event when the falling select is 1. With both selects set, either transition is an event.
- R6: In edge mode with the hold bit at 1, an event sets the pending bit, which stays set until a 1 is written to that bit of the pending word. Writing 0 leaves it unchanged.
- R7: In edge mode with the hold bit at 0, an event makes the pending bit 1 for exactly one cycle.
- R8: When an event and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R9: A hold bit can only be 1 while its type bit is 1. Hold writes are masked by the type word, and clearing a type bit clears its hold bit, as seen on readback.
- R10: `irq` is the OR over all 32 pins of (pending AND enable), registered one cycle after the pending and enable bits.
- R11: `irq_vec` gives the lowest-numbered pin, 0 to 31, whose pending and enable bits are both 1, registered alongside `irq`. `irq_vec_valid` is 0 when no pin qualifies.
- R12: A pending bit is set whether or not its enable bit is 1. A disabled pin's pending state stays readable but does not raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 32 | Asynchronous pin inputs, bit n is pin n |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 5 | Halfword address (byte address bits 5:1) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data for the address of the previous cycle |
| irq | output | 1 | Combined interrupt request |
| irq_vec_valid | output | 1 | High when some pin is pending and enabled |
| irq_vec | output | 5 | Lowest-numbered pending and enabled pin |

## Verification
The assertions assume that every bus write lasts one clock and that reset is held for at least one edge. They make no assumption about when pins toggle, because the synchroniser absorbs that. The vector checks treat the pending and enable words of the previous cycle as the only source of `irq` and `irq_vec`, so the stimulus never toggles pins right at a clock edge. Pins and bus signals are driven only on falling edges. Edge and set-versus-clear cases are placed by counting rising edges from the pin change, which puts the clearing write exactly on the cycle in which the event lands.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // The register map always has two halves; bus_addr[1] picks the half.
  localparam int NUM_HALVES = 2;
  localparam int WADDR_W    = 5;

  // Word selector taken from bus_addr[5:2]
  typedef enum logic [3:0] {
    SEL_PEND = 4'd2,
    SEL_EN   = 4'd3,
    SEL_TYPE = 4'd4,
    SEL_LVL  = 4'd5,
    SEL_HOLD = 4'd6,
    SEL_FALL = 4'd8,
    SEL_RISE = 4'd9
  } word_sel_e;

  function automatic logic sel_is_mapped(logic [3:0] s);
    case (s)
      4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd8, 4'd9: sel_is_mapped = 1'b1;
      default:                                  sel_is_mapped = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_half.sv
module gpio_irq_half
  import gpio_irq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [3:0]   wr_sel,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_s,
  output logic [W-1:0] pend,
  output logic [W-1:0] en,
  output logic [W-1:0] typ,
  output logic [W-1:0] lvl,
  output logic [W-1:0] hold,
  output logic [W-1:0] fall,
  output logic [W-1:0] rise
);

  logic [W-1:0] prev_q;
  logic [W-1:0] edge_ev, lvl_ev, ev, clr_mask, keep, pend_nxt;

  always_comb begin
    edge_ev  = (rise & pin_s & ~prev_q) | (fall & ~pin_s & prev_q);
    lvl_ev   = ~(pin_s ^ lvl);
    ev       = (typ & edge_ev) | (~typ & lvl_ev);
    clr_mask = (wr_en && wr_sel == SEL_PEND) ? wdata : '0;
    keep     = hold & pend & ~clr_mask;
    pend_nxt = ev | keep;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend   <= '0;
      en     <= '0;
      typ    <= '0;
      lvl    <= '1;
      hold   <= '0;
      fall   <= '0;
      rise   <= '0;
    end else begin
      prev_q <= pin_s;
      pend   <= pend_nxt;
      if (wr_en) begin
        case (wr_sel)
          SEL_EN:   en   <= wdata;
          SEL_TYPE: begin
            typ  <= wdata;
            hold <= hold & wdata;
          end
          SEL_LVL:  lvl  <= wdata;
          SEL_HOLD: hold <= wdata & typ;
          SEL_FALL: fall <= wdata;
          SEL_RISE: rise <= wdata;
          default:  ;
        endcase
      end
    end
  end

endmodule

// File: rtl/gpio_irq_prio.sv
module gpio_irq_prio #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int HALF_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int PINS       = HALF_W * NUM_HALVES,
  localparam int IDX_W      = $clog2(PINS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PINS-1:0]    pin_in,
  input  logic               bus_we,
  input  logic [WADDR_W-1:0] bus_addr,
  input  logic [HALF_W-1:0]  bus_wdata,
  output logic [HALF_W-1:0]  bus_rdata,
  output logic               irq,
  output logic               irq_vec_valid,
  output logic [IDX_W-1:0]   irq_vec
);

  logic [PINS-1:0] pin_s;
  logic [PINS-1:0] pend_all, en_all, typ_all, hold_all;

  logic [HALF_W-1:0] pend_h [NUM_HALVES];
  logic [HALF_W-1:0] en_h   [NUM_HALVES];
  logic [HALF_W-1:0] typ_h  [NUM_HALVES];
  logic [HALF_W-1:0] lvl_h  [NUM_HALVES];
  logic [HALF_W-1:0] hold_h [NUM_HALVES];
  logic [HALF_W-1:0] fall_h [NUM_HALVES];
  logic [HALF_W-1:0] rise_h [NUM_HALVES];

  logic [3:0] sel;
  logic       half_idx;
  assign sel      = bus_addr[4:1];
  assign half_idx = bus_addr[0];

  gpio_irq_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (pin_in),
    .q_sync  (pin_s)
  );

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    logic half_we;
    assign half_we = bus_we && (half_idx == h[0]) && sel_is_mapped(sel);

    gpio_irq_half #(.W(HALF_W)) u_half (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (half_we),
      .wr_sel (sel),
      .wdata  (bus_wdata),
      .pin_s  (pin_s[h*HALF_W +: HALF_W]),
      .pend   (pend_h[h]),
      .en     (en_h[h]),
      .typ    (typ_h[h]),
      .lvl    (lvl_h[h]),
      .hold   (hold_h[h]),
      .fall   (fall_h[h]),
      .rise   (rise_h[h])
    );

    assign pend_all[h*HALF_W +: HALF_W] = pend_h[h];
    assign en_all[h*HALF_W +: HALF_W]   = en_h[h];
    assign typ_all[h*HALF_W +: HALF_W]  = typ_h[h];
    assign hold_all[h*HALF_W +: HALF_W] = hold_h[h];
  end

  // Read mux, registered
  logic [HALF_W-1:0] rdata_nxt;
  always_comb begin
    case (sel)
      SEL_PEND: rdata_nxt = pend_h[half_idx];
      SEL_EN:   rdata_nxt = en_h[half_idx];
      SEL_TYPE: rdata_nxt = typ_h[half_idx];
      SEL_LVL:  rdata_nxt = lvl_h[half_idx];
      SEL_HOLD: rdata_nxt = hold_h[half_idx];
      SEL_FALL: rdata_nxt = fall_h[half_idx];
      SEL_RISE: rdata_nxt = rise_h[half_idx];
      default:  rdata_nxt = '0;
    endcase
  end

  // Qualification and priority
  logic [PINS-1:0]  qual;
  logic             any_q;
  logic [IDX_W-1:0] idx_c;
  assign qual = pend_all & en_all;

  gpio_irq_prio #(.N(PINS), .IDX_W(IDX_W)) u_prio (
    .req (qual),
    .any (any_q),
    .idx (idx_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata     <= '0;
      irq           <= 1'b0;
      irq_vec_valid <= 1'b0;
      irq_vec       <= '0;
    end else begin
      bus_rdata     <= rdata_nxt;
      irq           <= |qual;
      irq_vec_valid <= any_q;
      irq_vec       <= idx_c;
    end
  end

endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk #(
  parameter int PINS  = 32,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             irq,
  input logic             irq_vec_valid,
  input logic [IDX_W-1:0] irq_vec,
  input logic [PINS-1:0]  pend_all,
  input logic [PINS-1:0]  en_all,
  input logic [PINS-1:0]  typ_all,
  input logic [PINS-1:0]  hold_all
);

  logic [PINS-1:0] qual_q;
  logic [PINS-1:0] below_vec;

  always_ff @(posedge clk) begin
    if (rst) qual_q <= '0;
    else     qual_q <= pend_all & en_all;
  end

  assign below_vec = (PINS'(1) << irq_vec) - PINS'(1);

  // R1
  a_r1_enables_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> en_all == '0);

  // R9
  a_r9_hold_needs_edge: assert property (@(posedge clk) disable iff (rst)
    (hold_all & ~typ_all) == '0);

  // R10
  a_r10_irq_from_qualified: assert property (@(posedge clk) disable iff (rst)
    irq == (qual_q != '0));

  // R11
  a_r11_vec_is_lowest: assert property (@(posedge clk) disable iff (rst)
    irq_vec_valid |-> (qual_q[irq_vec] && ((qual_q & below_vec) == '0)));

  // R11
  a_r11_no_vec_when_idle: assert property (@(posedge clk) disable iff (rst)
    !irq_vec_valid |-> qual_q == '0);

endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(.PINS(PINS), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .irq           (irq),
  .irq_vec_valid (irq_vec_valid),
  .irq_vec       (irq_vec),
  .pend_all      (pend_all),
  .en_all        (en_all),
  .typ_all       (typ_all),
  .hold_all      (hold_all)
);

// File: tb/gpio_irq_unit_tb.sv
`timescale 1ns/1ps
module gpio_irq_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pin_in = '0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;
  logic        irq_vec_valid;
  logic [4:0]  irq_vec;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // byte offsets
  localparam logic [5:0] PEND_L = 6'h08, PEND_H = 6'h0a;
  localparam logic [5:0] EN_L   = 6'h0c, EN_H   = 6'h0e;
  localparam logic [5:0] TYP_L  = 6'h10, TYP_H  = 6'h12;
  localparam logic [5:0] LVL_L  = 6'h14;
  localparam logic [5:0] HOLD_L = 6'h18;
  localparam logic [5:0] FALL_L = 6'h20;
  localparam logic [5:0] RISE_L = 6'h24;

  // {pins, expected valid, expected vector}; all pins level, high active, enabled
  localparam int NV = 8;
  localparam logic [37:0] VTBL [NV] = '{
    {32'h0000_0000, 1'b0, 5'd0},
    {32'h0000_0010, 1'b1, 5'd4},
    {32'h8000_0000, 1'b1, 5'd31},
    {32'h0001_0000, 1'b1, 5'd16},
    {32'h8001_0100, 1'b1, 5'd8},
    {32'hFFFF_FFFF, 1'b1, 5'd0},
    {32'h0000_8000, 1'b1, 5'd15},
    {32'h0000_0000, 1'b0, 5'd0}
  };

  always #10 clk = ~clk;

  gpio_irq_unit u_dut (
    .clk           (clk),
    .rst           (rst),
    .pin_in        (pin_in),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .irq           (irq),
    .irq_vec_valid (irq_vec_valid),
    .irq_vec       (irq_vec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    bus_we = 1'b1; bus_addr = a[5:1]; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    bus_addr = a[5:1];
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 vec_valid", {31'd0, irq_vec_valid}, 32'd0);
    rd(EN_L, r);   chk("R1 enable low", {16'd0, r}, 32'h0);
    rd(LVL_L, r);  chk("R1 level low", {16'd0, r}, 32'hFFFF);
    rd(PEND_H, r); chk("R1 pending high", {16'd0, r}, 32'h0);

    // R2 register map
    wr(TYP_H, 16'hA5A5);
    rd(TYP_H, r);  chk("R2 type high readback", {16'd0, r}, 32'hA5A5);
    rd(TYP_L, r);  chk("R2 type low untouched", {16'd0, r}, 32'h0);
    rd(6'h00, r);  chk("R2 unmapped reads zero", {16'd0, r}, 32'h0);
    wr(6'h1c, 16'hFFFF);
    rd(6'h1c, r);  chk("R2 unmapped write ignored", {16'd0, r}, 32'h0);
    wr(TYP_H, 16'h0000);

    // R10 R11 table walk
    wr(EN_L, 16'hFFFF);
    wr(EN_H, 16'hFFFF);
    for (int i = 0; i < NV; i++) begin
      pin_in = VTBL[i][37:6];
      settle(4);
      chk("R10 irq table", {31'd0, irq}, {31'd0, VTBL[i][5]});
      chk("R11 valid table", {31'd0, irq_vec_valid}, {31'd0, VTBL[i][5]});
      if (VTBL[i][5]) chk("R11 vector table", {27'd0, irq_vec}, {27'd0, VTBL[i][4:0]});
    end

    // R4 low-active level
    wr(LVL_L, 16'hFFFE);
    settle(2);
    chk("R4 low active irq", {31'd0, irq}, 32'd1);
    chk("R4 low active vec", {27'd0, irq_vec}, 32'd0);
    wr(PEND_L, 16'h0001);
    settle(1);
    chk("R4 clear has no lasting effect", {31'd0, irq}, 32'd1);
    wr(LVL_L, 16'hFFFF);
    settle(2);
    chk("R4 inactive level irq", {31'd0, irq}, 32'd0);

    // R12 disabled pin still pends
    wr(EN_L, 16'h0000);
    pin_in = 32'h4;
    settle(4);
    chk("R12 disabled no irq", {31'd0, irq}, 32'd0);
    rd(PEND_L, r); chk("R12 pending visible", {16'd0, r}, 32'h4);
    pin_in = 32'h0;
    settle(4);
    wr(EN_L, 16'hFFFF);

    // R6 R5 edge hold, rising only
    wr(TYP_L, 16'h0008);
    wr(HOLD_L, 16'h0008);
    wr(RISE_L, 16'h0008);
    pin_in[3] = 1'b1;
    settle(4);
    chk("R5 rising irq", {31'd0, irq}, 32'd1);
    chk("R5 rising vec", {27'd0, irq_vec}, 32'd3);
    pin_in[3] = 1'b0;
    settle(4);
    chk("R6 held after pin drop", {31'd0, irq}, 32'd1);
    wr(PEND_L, 16'h0000);
    rd(PEND_L, r); chk("R6 write zero keeps", {16'd0, r}, 32'h8);
    wr(PEND_L, 16'h0008);
    rd(PEND_L, r); chk("R6 write one clears", {16'd0, r}, 32'h0);
    chk("R6 irq drops", {31'd0, irq}, 32'd0);

    // R5 falling only
    wr(FALL_L, 16'h0008);
    wr(RISE_L, 16'h0000);
    pin_in[3] = 1'b1;
    settle(4);
    rd(PEND_L, r); chk("R5 falling ignores rise", {16'd0, r}, 32'h0);
    pin_in[3] = 1'b0;
    settle(4);
    rd(PEND_L, r); chk("R5 falling detected", {16'd0, r}, 32'h8);
    wr(PEND_L, 16'h0008);

    // R5 both edges
    wr(RISE_L, 16'h0008);
    pin_in[3] = 1'b1;
    settle(4);
    rd(PEND_L, r); chk("R5 both rise", {16'd0, r}, 32'h8);
    wr(PEND_L, 16'h0008);
    rd(PEND_L, r); chk("R5 both cleared", {16'd0, r}, 32'h0);
    pin_in[3] = 1'b0;
    settle(4);
    rd(PEND_L, r); chk("R5 both fall", {16'd0, r}, 32'h8);
    wr(PEND_L, 16'h0008);

    // R9 hold masked by type
    wr(HOLD_L, 16'h00F0);
    rd(HOLD_L, r); chk("R9 hold masked", {16'd0, r}, 32'h0);
    wr(HOLD_L, 16'h00F8);
    rd(HOLD_L, r); chk("R9 hold on edge pin", {16'd0, r}, 32'h8);
    wr(TYP_L, 16'h0000);
    rd(HOLD_L, r); chk("R9 level clears hold", {16'd0, r}, 32'h0);

    // R7 through edge pulse
    wr(TYP_L, 16'h0008);
    wr(FALL_L, 16'h0000);
    pin_in[3] = 1'b1;
    settle(4);
    chk("R7 pulse high", {31'd0, irq}, 32'd1);
    settle(1);
    chk("R7 pulse one cycle", {31'd0, irq}, 32'd0);
    pin_in[3] = 1'b0;
    settle(4);

    // R8 set beats clear
    wr(HOLD_L, 16'h0008);
    wr(PEND_L, 16'hFFFF);
    pin_in[3] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    wr(PEND_L, 16'h0008);
    rd(PEND_L, r); chk("R8 set wins", {16'd0, r}, 32'h8);
    wr(PEND_L, 16'h0008);

    // R3 latency, high half
    pin_in[20] = 1'b1;
    settle(3);
    chk("R3 not yet", {31'd0, irq}, 32'd0);
    settle(1);
    chk("R3 irq on fourth edge", {31'd0, irq}, 32'd1);
    chk("R11 high half vec", {27'd0, irq_vec}, 32'd20);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule